// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit register datapath and a byte-addressed memory with a 32-bit data bus. Each request carries a base value, a signed 16-bit displacement, an access size, a load/store flag and a zero-extend flag. The unit adds the base and the displacement to get the effective address, and it checks that the address is naturally aligned. It then drives a word-aligned request toward memory, with one enable bit for each byte lane. For stores it places the source bytes on the lanes. For loads it picks the addressed byte or halfword out of the returned word and widens it to 32 bits.

Byte order is chosen per request by the `big_endian` pin. The pin is captured when the request is accepted, so a later change does not reach a load whose data is still on its way back. A misaligned access is never split into smaller accesses. The unit flags it and does not start it.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` follows `mem_ready`, so the memory's back-pressure passes straight to the requester. While `req_valid` is high and `req_ready` is low, the requester holds every request field steady. The response side has no back-pressure. `rsp_valid` is high for exactly one cycle after each accepted request, and the consumer must take `rsp_data` and `rsp_fault` in that cycle. The memory returns read data in the cycle after it accepts a read.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` equals the effective address with bits 1:0 cleared.
- R2: `req_size` codes are 00 for byte, 01 for halfword, and 10 or 11 for word. A byte access never faults. A halfword access faults when effective-address bit 0 is 1. A word access faults when bits 1:0 are not 00. `misalign_fault` is high in the same cycle as the request, while `req_valid` is high.
- R3: While `misalign_fault` is high, `mem_req` is low and `mem_be` is 0000. A misaligned store therefore changes no memory byte.
- R4: Lane L is bits 8L+7:8L of the memory bus, and `mem_be` bit L enables lane L. Let k be effective-address bits 1:0. In little-endian mode a byte uses lane k. In big-endian mode a byte uses lane 3-k. A halfword uses lanes 1:0 when k is 0 in little-endian mode or when k is 2 in big-endian mode, and lanes 3:2 in the other two cases. A word uses all four lanes. Loads and stores drive the same enables.
- R5: `mem_we` equals `req_store`. A byte store sends source bits 7:0 on all four lanes. A halfword store sends source bits 15:0 on both lane pairs. A word store sends the source word unchanged.
- R6: A load takes the byte or halfword from the lanes given in R4. Within a halfword, the higher lane is the most significant byte in both byte orders. A word load returns the bus word unchanged.
- R7: When `req_unsigned` is 0, a byte or halfword load copies its top bit into all upper bits of `rsp_data`. When `req_unsigned` is 1, the upper bits are filled with zeros.
- R8: `req_ready` follows `mem_ready`. `rsp_valid` is high in the cycle after each accepted request and low after every cycle with no acceptance. Nothing is accepted while `req_ready` is low.
- R9: `rsp_fault` reports the alignment fault of the accepted request. `rsp_data` is zero for a faulted access and for a store.
- R10: Byte order, size, lane offset and extension mode are captured when the request is accepted. Changing `big_endian` during the response cycle does not change `rsp_data`.
- R11: During and just after reset, `rsp_valid` is 0, and `mem_req` is 0 while no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend a load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| big_endian | input | 1 | Byte order for this request |
| misalign_fault | output | 1 | Current request is misaligned |
| mem_req | output | 1 | Memory access strobe |
| mem_ready | input | 1 | Memory can take an access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read |
| rsp_valid | output | 1 | Response for the previous accepted request |
| rsp_fault | output | 1 | That request was misaligned |
| rsp_data | output | 32 | Extended load result |

## Verification
The assertions assume that a requester facing a low `req_ready` keeps its fields steady. They also assume that the memory follows `mem_ready` and returns read data exactly one cycle after accepting a read. The bench's memory model does both, and its driver changes request fields only at a falling edge while a request is pending. The properties also assume that nothing downstream stalls a response. The bench therefore takes every response in the cycle it appears. It keeps every word of memory in a single byte order, so that the expected values, which are computed per byte address, stay well defined.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } acc_size_e;

  // Fields captured when a request is accepted, used in the response cycle.
  typedef struct packed {
    logic      is_load;
    logic      fault;
    acc_size_e size;
    logic      zext;
    logic      big;
  } rsp_meta_t;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0]    base,
  input  logic [OFF_W-1:0]     offset,
  input  acc_size_e            size,
  output logic [ADDR_W-1:0]    word_addr,
  output logic [LANE_BITS-1:0] lane_off,
  output logic                 misaligned
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] eff;

  assign eff       = base + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane_off  = eff[LANE_BITS-1:0];
  assign word_addr = {eff[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = eff[0];
      default: misaligned = |eff[LANE_BITS-1:0];
    endcase
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         enable,
  input  acc_size_e                    size,
  input  logic                         big,
  input  logic [$clog2(DATA_W/8)-1:0]  lane_off,
  input  logic [DATA_W-1:0]            src,
  output logic [DATA_W/8-1:0]          be,
  output logic [DATA_W-1:0]            lane_data
);

  localparam int LANES  = DATA_W / 8;
  localparam int LB     = $clog2(LANES);
  localparam int HALVES = LANES / 2;
  localparam int HB     = (LB > 1) ? LB - 1 : 1;
  localparam logic [LB-1:0] TOP_LANE = LB'(LANES - 1);
  localparam logic [HB-1:0] TOP_HALF = HB'(HALVES - 1);

  logic [LB-1:0] byte_lane;
  logic [HB-1:0] half_idx;
  logic [HB-1:0] half_lane;

  assign byte_lane = big ? (TOP_LANE - lane_off) : lane_off;
  assign half_idx  = lane_off[LB-1:1];
  assign half_lane = big ? (TOP_HALF - half_idx) : half_idx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LB-1:0] LANE_ID = LB'(g);
    localparam logic [HB-1:0] PAIR_ID = HB'(g / 2);
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (LANE_ID == byte_lane);
        SZ_HALF: hit = (PAIR_ID == half_lane);
        default: hit = 1'b1;
      endcase
    end
    assign be[g] = enable & hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: lane_data[8*g +: 8] = src[7:0];
        SZ_HALF: lane_data[8*g +: 8] = src[8*(g%2) +: 8];
        default: lane_data[8*g +: 8] = src[8*g +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         pass,
  input  acc_size_e                    size,
  input  logic                         zext,
  input  logic                         big,
  input  logic [$clog2(DATA_W/8)-1:0]  lane_off,
  input  logic [DATA_W-1:0]            rdata,
  output logic [DATA_W-1:0]            result
);

  localparam int LANES  = DATA_W / 8;
  localparam int LB     = $clog2(LANES);
  localparam int HALVES = LANES / 2;
  localparam int HB     = (LB > 1) ? LB - 1 : 1;
  localparam logic [LB-1:0] TOP_LANE = LB'(LANES - 1);
  localparam logic [HB-1:0] TOP_HALF = HB'(HALVES - 1);

  logic [7:0]    lane_b [LANES];
  logic [15:0]   pair_h [HALVES];
  logic [LB-1:0] byte_lane;
  logic [HB-1:0] half_lane;
  logic [7:0]    sel_b;
  logic [15:0]   sel_h;
  logic [DATA_W-1:0] ext;

  for (genvar g = 0; g < LANES; g++) begin : g_b
    assign lane_b[g] = rdata[8*g +: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_h
    assign pair_h[h] = rdata[16*h +: 16];
  end

  assign byte_lane = big ? (TOP_LANE - lane_off) : lane_off;
  assign half_lane = big ? (TOP_HALF - lane_off[LB-1:1]) : lane_off[LB-1:1];
  assign sel_b     = lane_b[byte_lane];
  assign sel_h     = pair_h[half_lane];

  always_comb begin
    unique case (size)
      SZ_BYTE: ext = {{(DATA_W-8){sel_b[7] & ~zext}}, sel_b};
      SZ_HALF: ext = {{(DATA_W-16){sel_h[15] & ~zext}}, sel_h};
      default: ext = rdata;
    endcase
  end

  assign result = pass ? ext : '0;

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              big_endian,
  output logic              misalign_fault,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  acc_size_e            size_in;
  logic [LANE_BITS-1:0] lane_off;
  logic                 misaligned;
  logic                 accept;
  logic                 go;

  rsp_meta_t            meta_q;
  logic [LANE_BITS-1:0] off_q;
  logic                 rsp_valid_q;

  assign size_in = acc_size_e'(req_size);

  lsu_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_BITS(LANE_BITS)
  ) u_addr (
    .base(req_base), .offset(req_offset), .size(size_in),
    .word_addr(mem_addr), .lane_off(lane_off), .misaligned(misaligned)
  );

  assign go             = req_valid & ~misaligned;
  assign misalign_fault = req_valid & misaligned;
  assign mem_req        = go;
  assign mem_we         = req_store;
  assign req_ready      = mem_ready;
  assign accept         = req_valid & req_ready;

  lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
    .enable(go), .size(size_in), .big(big_endian), .lane_off(lane_off),
    .src(req_wdata), .be(mem_be), .lane_data(mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      meta_q      <= '0;
      off_q       <= '0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) begin
        meta_q.is_load <= ~req_store;
        meta_q.fault   <= misaligned;
        meta_q.size    <= size_in;
        meta_q.zext    <= req_unsigned;
        meta_q.big     <= big_endian;
        off_q          <= lane_off;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .pass(rsp_valid_q & meta_q.is_load & ~meta_q.fault),
    .size(meta_q.size), .zext(meta_q.zext), .big(meta_q.big),
    .lane_off(off_q), .rdata(mem_rdata), .result(rsp_data)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_valid_q & meta_q.fault;

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int DATA_W    = 32,
  parameter int LANE_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_size,
  input logic                 misalign_fault,
  input logic                 mem_req,
  input logic [LANE_BITS-1:0] mem_addr_lo,
  input logic [DATA_W/8-1:0]  mem_be,
  input logic                 rsp_valid,
  input logic                 rsp_fault,
  input logic [DATA_W-1:0]    rsp_data
);

  AST_FAULT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_fault |-> (!mem_req && mem_be == '0)); // R3
  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr_lo == '0)); // R1
  AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |-> !misalign_fault); // R2
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'b00) |-> ($countones(mem_be) == 1)); // R4
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'b01) |-> ($countones(mem_be) == 2)); // R4
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R8
  AST_FAULT_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_fault == $past(misalign_fault))); // R9
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_data == '0)); // R9

endmodule

bind lsu_lane_align lsu_lane_align_chk #(
  .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .misalign_fault(misalign_fault), .mem_req(mem_req),
  .mem_addr_lo(mem_addr[LANE_BITS-1:0]), .mem_be(mem_be),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
);

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [15:0] req_offset = '0;
  logic        big_endian = 1'b0, mem_ready = 1'b1;
  logic        req_ready, misalign_fault, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] ram [16];
  logic [7:0]  shadow [64];
  logic [32:0] expq [$];

  always #10 clk = ~clk;

  lsu_lane_align uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .big_endian(big_endian), .misalign_fault(misalign_fault), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  // Memory model: lane-based word store, read data one cycle later.
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) ram[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[5:2]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected response per rsp_valid (R6 R7 R9 R10).
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) begin
        chk("R8 response with none expected", 32'd1, 32'd0);
      end else begin
        logic [32:0] e;
        e = expq.pop_front();
        chk("R9 response fault flag", {31'd0, rsp_fault}, {31'd0, e[32]});
        chk("R6 R7 response data", rsp_data, e[31:0]);
      end
    end
  end

  task automatic send(input logic st, input logic [1:0] sz, input logic uns,
                      input logic [31:0] base, input logic [15:0] ofs,
                      input logic [31:0] wd, input logic big, input logic flip);
    logic [31:0] ea, val, ewd;
    logic [3:0]  ebe;
    logic        efault;
    int          n, lane;
    ea = base + {{16{ofs[15]}}, ofs};
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    efault = (sz == 2'b00) ? 1'b0 : (sz == 2'b01) ? ea[0] : (ea[1:0] != 2'b00);
    if (sz == 2'b00) begin
      lane = big ? 3 - int'(ea[1:0]) : int'(ea[1:0]);
      ebe = 4'b0001 << lane;
      ewd = {4{wd[7:0]}};
    end else if (sz == 2'b01) begin
      ebe = ((big ? ~ea[1] : ea[1])) ? 4'b1100 : 4'b0011;
      ewd = {2{wd[15:0]}};
    end else begin
      ebe = 4'b1111;
      ewd = wd;
    end
    if (efault) ebe = 4'b0000;
    val = '0;
    for (int i = 0; i < n; i++) begin
      if (big) val = (val << 8) | {24'd0, shadow[(ea + i) % 64]};
      else     val = val | ({24'd0, shadow[(ea + i) % 64]} << (8 * i));
    end
    if (sz == 2'b00 && !uns) val = {{24{val[7]}}, val[7:0]};
    if (sz == 2'b01 && !uns) val = {{16{val[15]}}, val[15:0]};
    if (st || efault) val = '0;

    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_base = base; req_offset = ofs; req_wdata = wd; big_endian = big;
    #5;
    chk("R2 misalign fault", {31'd0, misalign_fault}, {31'd0, efault});
    chk("R3 mem_req gated", {31'd0, mem_req}, {31'd0, ~efault});
    chk("R1 word address", mem_addr, {ea[31:2], 2'b00});
    chk("R4 byte enables", {28'd0, mem_be}, {28'd0, ebe});
    chk("R5 write flag", {31'd0, mem_we}, {31'd0, st});
    if (st && !efault) chk("R5 store lanes", mem_wdata, ewd);
    while (!req_ready) begin
      @(negedge clk); #5;
      chk("R8 no response while stalled", {31'd0, rsp_valid}, 32'd0);
    end
    expq.push_back({efault, val});
    @(posedge clk);
    if (st && !efault)
      for (int i = 0; i < n; i++)
        shadow[(ea + i) % 64] = big ? wd[8*(n-1-i) +: 8] : wd[8*i +: 8];
    if (flip) begin
      #1 big_endian = ~big;   // R10: order change during response cycle
    end
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = '0;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    #5;
    chk("R11 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11 mem_req idle", {31'd0, mem_req}, 32'd0);

    // Little-endian word at 4 (negative displacement), then byte/half loads: R4 R6 R7
    send(1, 2'b10, 0, 32'h20, 16'hFFE4, 32'h01234567, 0, 0);
    send(0, 2'b00, 1, 32'h4, 16'h0, '0, 0, 0);
    send(0, 2'b00, 1, 32'h4, 16'h3, '0, 0, 0);
    send(0, 2'b01, 0, 32'h4, 16'h2, '0, 0, 0);
    send(0, 2'b10, 0, 32'h40, 16'hFFC4, '0, 0, 0);  // R1 base 0x40 - 60
    // Big-endian word at 8, sign and zero extension: R7
    send(1, 2'b10, 0, 32'h8, 16'h0, 32'h89ABCDEF, 1, 0);
    send(0, 2'b00, 0, 32'h8, 16'h0, '0, 1, 0);
    send(0, 2'b00, 1, 32'h8, 16'h3, '0, 1, 0);
    send(0, 2'b01, 0, 32'h8, 16'h2, '0, 1, 0);
    send(0, 2'b01, 1, 32'h8, 16'h2, '0, 1, 0);
    send(0, 2'b11, 0, 32'h8, 16'h0, '0, 1, 0);      // R2 code 11 is a word
    // Sub-word stores: R5
    send(1, 2'b00, 0, 32'hC, 16'h1, 32'h1234565A, 1, 0);
    send(1, 2'b01, 0, 32'h10, 16'h2, 32'h7777BEEF, 0, 0);
    send(0, 2'b00, 0, 32'hC, 16'h1, '0, 1, 0);
    send(0, 2'b01, 0, 32'h10, 16'h2, '0, 0, 0);
    send(0, 2'b00, 1, 32'h10, 16'h3, '0, 0, 0);
    send(0, 2'b01, 1, 32'hC, 16'h0, '0, 1, 0);
    // Misaligned accesses: R2 R3 R9
    send(0, 2'b01, 0, 32'h4, 16'h1, '0, 0, 0);
    send(0, 2'b10, 0, 32'h4, 16'h2, '0, 1, 0);
    send(1, 2'b10, 0, 32'h0, 16'h2, 32'hDEADBEEF, 0, 0);
    send(0, 2'b10, 0, 32'h0, 16'h0, '0, 0, 0);     // R3 nothing written
    send(0, 2'b00, 1, 32'h5, 16'h0, '0, 0, 0);     // R2 odd byte ok
    // R10: byte order flipped while the response is returning
    send(0, 2'b00, 1, 32'h8, 16'h0, '0, 1, 1);
    send(0, 2'b01, 1, 32'h4, 16'h2, '0, 0, 1);
    // R8: back-pressure from memory
    idle(2);
    mem_ready = 1'b0;
    fork
      begin repeat (3) @(negedge clk); mem_ready = 1'b1; end
    join_none
    send(0, 2'b10, 0, 32'h4, 16'h0, '0, 0, 0);
    idle(3);
    chk("R8 all responses returned", expq.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule